// File: doc/BRIEF.md
# Stochastic Bitstream Dense Spiking Layer

This block is a fully connected layer of `N_IN` inputs and `M_OUT` spiking neurons that does its multiplications in the stochastic domain. Each input operand and each weight has its own encoder. An encoder is a 16-bit LFSR whose state is compared against the operand, so it emits a unipolar bitstream. The probability of a 1 in that stream is the operand divided by 65536. Each weight stream is ANDed with the stream of its input. The product bits for each neuron are counted over a window of `WIN_LEN` running cycles.

When a window ends, each neuron's count is scaled to a signed Q8.8 current. That current drives one leaky integrate-and-fire step for the neuron. A neuron whose membrane value reaches the threshold emits a spike in the same cycle as the done pulse, and its membrane value returns to zero.

A host uses the block as follows. It holds the input, weight and threshold buses steady and pulses `start`. It waits for `done`, then samples `spike`. Every encoder has a fixed seed derived from its lane index, so the same stimulus sequence always produces the same spike pattern.

Top module: `stoch_dense_layer`

## Requirements
- R1: After reset, `done` and every `spike` bit are 0, every membrane value is 0, every encoder holds its seed, and no window runs until `start` is seen.
- R2: A `start` sampled while the layer is idle begins a window. `done` is 1 for exactly one cycle, in the cycle after the `WIN_LEN`-th rising edge that follows the edge that accepted `start`. The per-neuron counts are zero while `done` is high.
- R3: A `start` sampled while a window is running has no effect, including at the last edge of the window. It does not shift the done pulse and it does not start a further window.
- R4: An encoder outputs 1 in a cycle exactly when its LFSR state is strictly less than its 16-bit operand. An operand of 0 therefore never produces a 1.
- R5: Each LFSR steps once per running cycle as `next = {s[0]^s[2]^s[3]^s[5], s[15:1]}` (polynomial x^16+x^14+x^13+x^11+1). It holds its state while the layer is idle and is not reseeded between windows.
- R6: The encoder for input i (operand `in_vals[16*i +: 16]`) is seeded with (0xACE1 + 7*i) mod 2^16. The encoder for weight k = j*N_IN + i (operand `wt_vals[16*k +: 16]`, input i to neuron j) is seeded with (0xBEEF + 13*k) mod 2^16. A seed of zero is replaced by 0x0001.
- R7: Each running cycle, neuron j counts the number of inputs i whose input bit AND weight bit k = j*N_IN + i are both 1. At the end of the window the count c becomes the current I = c*256/WIN_LEN (`WIN_LEN` a power of two from 2 to 256), clamped to 0x7FFF.
- R8: At the end of each window every neuron computes V' = V - (V >>> 4) + I in signed two's-complement Q8.8, saturating to the range -32768..32767.
- R9: If V' is greater than or equal to the signed threshold `fire_thr`, the neuron's spike bit is 1 for the single cycle in which `done` is high, and V becomes 0. Otherwise V becomes V' and the spike bit stays 0. Spike bits are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin-window strobe, honoured only when idle |
| in_vals | input | 16*N_IN | Input operands, lane i at bits 16*i |
| wt_vals | input | 16*N_IN*M_OUT | Weight operands, lane j*N_IN+i at bits 16*(j*N_IN+i) |
| fire_thr | input | 16 | Signed Q8.8 firing threshold |
| spike | output | M_OUT | Per-neuron spike, valid with done |
| done | output | 1 | One-cycle end-of-window pulse |

## Verification
The hardest situation to reach from the ports is a `start` strobe that arrives while a window is running, above all one sampled on the very edge that closes the window. At that edge the layer is still busy, so the strobe must be dropped. The bench raises `start` once in the middle of a window and once on the cycle before the closing edge. It then watches for more than a full window length to make sure no second done pulse appears. The bench tracks every encoder lane itself, so any extra LFSR step caused by a wrongly accepted strobe also shows up as a wrong spike pattern in the later windows.

// File: rtl/stoch_pkg.sv
package stoch_pkg;

  localparam int unsigned LANE_W = 16;

  // one Fibonacci step, right-shifting form of x^16+x^14+x^13+x^11+1
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  function automatic logic [15:0] seed_guard(input logic [15:0] s);
    return (s == 16'h0000) ? 16'h0001 : s;
  endfunction

  function automatic logic [15:0] seed_input(input int unsigned idx);
    logic [31:0] t;
    t = 32'h0000_ACE1 + 32'(7 * idx);
    return seed_guard(t[15:0]);
  endfunction

  function automatic logic [15:0] seed_weight(input int unsigned idx);
    logic [31:0] t;
    t = 32'h0000_BEEF + 32'(13 * idx);
    return seed_guard(t[15:0]);
  endfunction

  // leaky integration in Q8.8 with saturation
  function automatic logic signed [15:0] lif_next(input logic signed [15:0] v,
                                                  input logic signed [15:0] cur);
    logic signed [15:0] leak;
    logic signed [17:0] w;
    leak = v >>> 4;
    w = {{2{v[15]}}, v} - {{2{leak[15]}}, leak} + {{2{cur[15]}}, cur};
    if (w > 18'sd32767)       return 16'sh7FFF;
    else if (w < -18'sd32768) return 16'sh8000;
    else                      return w[15:0];
  endfunction

endpackage

// File: rtl/sc_encoder.sv
module sc_encoder #(
  parameter logic [15:0] SEED = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic [15:0] operand,
  output logic        bit_o,
  output logic [15:0] state_o
);
  import stoch_pkg::*;

  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   state_q <= SEED;
    else if (adv) state_q <= lfsr_step(state_q);
  end

  assign bit_o   = (state_q < operand);
  assign state_o = state_q;
endmodule

// File: rtl/lif_cell.sv
module lif_cell (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               update,
  input  logic signed [15:0] cur,
  input  logic signed [15:0] thr,
  output logic               spike
);
  import stoch_pkg::*;

  logic signed [15:0] v_q;
  logic signed [15:0] v_cand;
  logic               fire;

  assign v_cand = lif_next(v_q, cur);
  assign fire   = (v_cand >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      spike <= 1'b0;
    end else if (update) begin
      v_q   <= fire ? 16'sd0 : v_cand;
      spike <= fire;
    end else begin
      spike <= 1'b0;
    end
  end
endmodule

// File: rtl/stoch_dense_layer.sv
module stoch_dense_layer #(
  parameter int N_IN    = 2,
  parameter int M_OUT   = 2,
  parameter int WIN_LEN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [16*N_IN-1:0]            in_vals,
  input  logic [16*N_IN*M_OUT-1:0]      wt_vals,
  input  logic signed [15:0]            fire_thr,
  output logic [M_OUT-1:0]              spike,
  output logic                          done
);
  import stoch_pkg::*;

  localparam int NW  = N_IN * M_OUT;
  localparam int CW  = $clog2(N_IN * WIN_LEN + 1);
  localparam int WB  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int SH  = 8 - $clog2(WIN_LEN);
  localparam int LFW = (N_IN + NW) * 16;

  function automatic logic signed [15:0] to_current(input logic [CW-1:0] c);
    logic [31:0] w;
    w = 32'(c) << SH;
    if (w > 32'h0000_7FFF) return 16'sh7FFF;
    return $signed(w[15:0]);
  endfunction

  // named internal events for the checker
  logic                 busy;
  logic                 win_end;
  logic [WB-1:0]        cnt_q;
  logic [M_OUT*CW-1:0]  acc_all;
  logic [LFW-1:0]       lfsr_all;
  logic [N_IN-1:0]      in_bit;
  logic [NW-1:0]        wt_bit;

  assign win_end = busy && (cnt_q == WB'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= win_end;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt_q <= '0;
        end
      end else if (win_end) begin
        busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    sc_encoder #(.SEED(seed_input(i))) u_enc (
      .clk(clk), .rst_n(rst_n), .adv(busy),
      .operand(in_vals[16*i +: 16]),
      .bit_o(in_bit[i]),
      .state_o(lfsr_all[16*i +: 16])
    );
  end

  for (genvar k = 0; k < NW; k++) begin : g_wt
    sc_encoder #(.SEED(seed_weight(k))) u_enc (
      .clk(clk), .rst_n(rst_n), .adv(busy),
      .operand(wt_vals[16*k +: 16]),
      .bit_o(wt_bit[k]),
      .state_o(lfsr_all[16*(N_IN+k) +: 16])
    );
  end

  for (genvar j = 0; j < M_OUT; j++) begin : g_nrn
    logic [CW-1:0]      pc;
    logic [CW-1:0]      acc_q;
    logic [CW-1:0]      acc_sum;
    logic signed [15:0] cur;

    always_comb begin
      pc = '0;
      for (int i = 0; i < N_IN; i++)
        pc = pc + CW'(in_bit[i] & wt_bit[j*N_IN + i]);
    end

    assign acc_sum = acc_q + pc;
    assign cur     = to_current(acc_sum);

    always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (win_end) acc_q <= '0;
      else if (busy)    acc_q <= acc_sum;
    end

    assign acc_all[CW*j +: CW] = acc_q;

    lif_cell u_cell (
      .clk(clk), .rst_n(rst_n), .update(win_end),
      .cur(cur), .thr(fire_thr), .spike(spike[j])
    );
  end
endmodule

// File: rtl/stoch_dense_chk.sv
module stoch_dense_chk #(
  parameter int M_OUT = 2,
  parameter int ACC_W = 7,
  parameter int LF_W  = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              win_end,
  input logic [M_OUT-1:0]  spike,
  input logic [M_OUT*ACC_W-1:0] acc_all,
  input logic [LF_W-1:0]   lfsr_all
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");

  assert_acc_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_all == '0)) else $error("counts not cleared at done");

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !win_end) |=> busy) else $error("window aborted early");

  assert_accept_only_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)) else $error("window began without start");

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(lfsr_all)) else $error("LFSR moved while idle");

  assert_run_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$stable(lfsr_all)) else $error("LFSR stalled while running");

  assert_spike_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|spike) |-> done) else $error("spike outside done cycle");
endmodule

bind stoch_dense_layer stoch_dense_chk #(
  .M_OUT(M_OUT), .ACC_W(CW), .LF_W(LFW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .win_end(win_end), .spike(spike), .acc_all(acc_all), .lfsr_all(lfsr_all)
);

// File: tb/test_stoch_dense_layer.sv
module test_stoch_dense_layer;
  localparam int N   = 2;
  localparam int M   = 2;
  localparam int WIN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [16*N-1:0]   in_vals = '0;
  logic [16*N*M-1:0] wt_vals = '0;
  logic signed [15:0] fire_thr = 16'sd1;
  logic [M-1:0] spike;
  logic done;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model state
  logic [15:0] m_lin [N];
  logic [15:0] m_lwt [N*M];
  int          m_v   [M];
  logic [M-1:0] exp_spk;

  always #5 clk = ~clk;

  stoch_dense_layer #(.N_IN(N), .M_OUT(M), .WIN_LEN(WIN)) i_stoch_dense_layer (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vals(in_vals),
    .wt_vals(wt_vals), .fire_thr(fire_thr), .spike(spike), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_step(input logic [15:0] s);
    logic fb;
    fb = ^(s & 16'h002D);
    return (s >> 1) | {fb, 15'd0};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_lin[i] = 16'(32'hACE1 + 7*i);
    for (int k = 0; k < N*M; k++) m_lwt[k] = 16'(32'hBEEF + 13*k);
    for (int j = 0; j < M; j++) m_v[j] = 0;
  endtask

  // R4 R5 R6 R7 R8 R9 expected result of one window
  task automatic model_window();
    int cnt [M];
    for (int j = 0; j < M; j++) cnt[j] = 0;
    for (int c = 0; c < WIN; c++) begin
      for (int j = 0; j < M; j++)
        for (int i = 0; i < N; i++)
          if ((m_lin[i] < in_vals[16*i +: 16]) && (m_lwt[j*N+i] < wt_vals[16*(j*N+i) +: 16]))
            cnt[j]++;
      for (int i = 0; i < N; i++) m_lin[i] = m_step(m_lin[i]);
      for (int k = 0; k < N*M; k++) m_lwt[k] = m_step(m_lwt[k]);
    end
    for (int j = 0; j < M; j++) begin
      int cur, vn;
      cur = (cnt[j] * 256) / WIN;
      if (cur > 32767) cur = 32767;
      vn = m_v[j] - (m_v[j] >>> 4) + cur;
      if (vn > 32767) vn = 32767;
      if (vn < -32768) vn = -32768;
      if (vn >= int'(fire_thr)) begin
        exp_spk[j] = 1'b1;
        m_v[j] = 0;
      end else begin
        exp_spk[j] = 1'b0;
        m_v[j] = vn;
      end
    end
  endtask

  // one window; poke_a/poke_b: cycles at which a stray start is raised (-1 none)
  task automatic run_window(input string req, input int poke_a, input int poke_b);
    model_window();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < WIN; c++) begin
      check(done == 1'b0, "R2 done early", int'(done), 0);
      start = (c == poke_a || c == poke_b);
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1, "R2 done timing", int'(done), 1);
    check(spike == exp_spk, req, int'(spike), int'(exp_spk));
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", int'(done), 0);
    check(spike == '0, "R9 spike one cycle", int'(spike), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(spike == '0, "R1 reset spike", int'(spike), 0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(done == 1'b0, "R1 idle without start", int'(done), 0);
    end
  endtask

  task automatic t_zero_operands();
    in_vals = '0;
    wt_vals = {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    fire_thr = 16'sd1;
    run_window("R4 zero operand no spike", -1, -1);
    check(exp_spk == '0, "R4 model zero", int'(exp_spk), 0);
    run_window("R4 zero operand second window", -1, -1);
  endtask

  task automatic t_negative_thr();
    fire_thr = -16'sd1;
    run_window("R9 negative threshold fires", -1, -1);
    check(spike == '0 && exp_spk == '1, "R9 all fire expected", int'(exp_spk), 3);
    fire_thr = 16'sd1;
  endtask

  task automatic t_full();
    in_vals = {16'hFFFF, 16'hFFFF};
    wt_vals = {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    fire_thr = 16'sh0180;
    for (int w = 0; w < 3; w++) run_window("R7 R8 full operands", -1, -1);
  endtask

  task automatic t_mixed();
    in_vals = {16'h4000, 16'h8000};
    wt_vals = {16'hF000, 16'h6000, 16'h2000, 16'hC000};
    fire_thr = 16'sh0060;
    for (int w = 0; w < 6; w++) run_window("R6 R5 mixed operands", -1, -1);
    in_vals = {16'hA000, 16'h3000};
    fire_thr = 16'sh0100;
    for (int w = 0; w < 4; w++) run_window("R8 R9 leak and threshold", -1, -1);
  endtask

  task automatic t_restart_ignored();
    in_vals = {16'h7000, 16'hB000};
    wt_vals = {16'h9000, 16'h5000, 16'hE000, 16'h8000};
    fire_thr = 16'sh0050;
    run_window("R3 start in window ignored", 5, WIN - 1);
    for (int c = 0; c < WIN + 3; c++) begin
      @(negedge clk);
      check(done == 1'b0, "R3 no extra window", int'(done), 0);
    end
    run_window("R3 later window unshifted", -1, -1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_operands();
    t_negative_thr();
    t_full();
    t_mixed();
    t_restart_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule